// File: doc/BRIEF.md
# Addressed Serial-Load DAC Register Bank

This block is the digital front end of an eight-channel multiplying digital-to-analog converter. A host sends 12-bit frames over three wires: a serial data line, a shift clock and a load strobe. All three are sampled by a faster system clock. While the load strobe is low, each rising shift-clock edge moves one data bit into a 12-bit frame register, most significant bit first. When the strobe rises, the upper four bits of the frame select a channel and the lower eight bits become that channel's code.

The eight 8-bit channel codes drive the converter cells, which are not part of this block. A serial output carries the bit pushed out of the far end of the frame register. Several devices can therefore share one data line in a chain, and each downstream device sees the stream twelve shift clocks later. Select values that name no channel change nothing. An active-low reset returns every channel code to zero.

Top module: `dac_serial_bank`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, every channel code on `ch_code` reads zero after that edge.
- R2: A 12-bit frame is shifted in with its first bit as F11 and its twelfth bit as F0. After the load, the selected channel's code equals F7..F0, with F0 as the least significant bit.
- R3: `sdi` is taken only on a rising edge of `sclk`. Changes of `sdi` while `sclk` is steady have no effect on the loaded code.
- R4: Rising `sclk` edges that arrive while `ld` is high do not change the frame register, so a later bare strobe pulse reloads the previous frame.
- R5: One strobe rising edge writes at most one channel. All other channel codes hold their values.
- R6: The select field F11..F8, read as an unsigned number k, picks channel k for k from 1 to 8. Channel k occupies `ch_code[8k-1:8k-8]`.
- R7: Select values 0 and 9 to 15 leave all eight channel codes unchanged.
- R8: `sdo` equals the bit that was shifted in twelve shifts earlier, and 0 if fewer than twelve shifts have occurred since reset.
- R9: After `ld` rises at the pin, the written code is not visible after the second `clk` rising edge and is visible after the third.
- R10: A channel keeps its code until a later frame selects it, and the most recent write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data in |
| sclk | input | 1 | Serial shift clock; idles high |
| ld | input | 1 | Load strobe; low enables shifting, rising edge commits |
| sdo | output | 1 | Chain output, bit leaving the frame register |
| ch_code | output | 64 | Eight 8-bit channel codes, channel 1 in the low byte |

## Verification
A corrupted frame register shows up first on `sdo`, twelve shifts after the bad bit entered. On the channel outputs it appears at the next strobe, as a wrong code or a write to the wrong channel. A broken edge detector or synchroniser shows as extra or missing shifts, which shifts every later bit of the stream by one position. It also shows as a strobe that commits one cycle early or late. The bench compares both outputs against a behavioural model on every clock, so such a fault is reported within the cycle after it first reaches a port.

// File: rtl/dsb_pkg.sv
// Package: shared sizes for the serial DAC register bank.
// Assumes one frame = select field above code field, nothing else.
package dsb_pkg;
    localparam int CH_N    = 8;   // number of channels
    localparam int CODE_W  = 8;   // bits per channel code
    localparam int SEL_W   = 4;   // bits in the channel select field
    localparam int FRAME_W = SEL_W + CODE_W;
endpackage

// File: rtl/dsb_sync_edge.sv
// Module: dsb_sync_edge
// Brings W asynchronous pins into the clk domain through two flops and
// flags rising edges of the synchronised levels.
// Assumes each pin holds a level for at least two clk cycles.
module dsb_sync_edge #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    // Two-stage synchroniser plus a delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            lvl_q  <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= pin;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    // Rising edge: level high now, low one cycle ago.
    always_comb begin
        lvl  = lvl_q;
        rise = lvl_q & ~prev_q;
    end
endmodule

// File: rtl/dsb_shift.sv
// Module: dsb_shift
// Frame register that shifts in one bit, MSB first, on each shift strobe.
// The far-end bit is the chain output.
// Assumes shift_en has already been gated by the load level.
module dsb_shift #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame,
    output logic               chain_out
);
    logic [FRAME_W-1:0] sr_q;

    // Shift toward the MSB end; new bit enters at position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[FRAME_W-2:0], bit_in};
        end
    end

    // Expose the frame and the bit that leaves on the next shift.
    always_comb begin
        frame     = sr_q;
        chain_out = sr_q[FRAME_W-1];
    end
endmodule

// File: rtl/dsb_latch_bank.sv
// Module: dsb_latch_bank
// Decodes the select field of a committed frame and writes its code
// into the selected channel latch. Select k (1..CH_N) picks channel k.
// Any other select value writes nothing.
module dsb_latch_bank #(
    parameter int CH_N   = 8,
    parameter int CODE_W = 8,
    parameter int SEL_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [SEL_W-1:0]         sel,
    input  logic [CODE_W-1:0]        code,
    output logic [CH_N*CODE_W-1:0]   codes
);
    logic [CH_N-1:0] wr_en;

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic [CODE_W-1:0] val_q;

        // One-hot write enable for this channel.
        always_comb begin
            wr_en[g] = commit && (sel == SEL_W'(g + 1));
        end

        // Channel latch: cleared on reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en[g]) begin
                val_q <= code;
            end
        end

        assign codes[g*CODE_W +: CODE_W] = val_q;
    end
endmodule

// File: rtl/dac_serial_bank.sv
// Module: dac_serial_bank (top)
// Serial three-wire front end of an eight-channel DAC. It synchronises
// the pins, shifts frames while the strobe is low and commits on the
// strobe's rising edge. Assumes the shift clock and strobe idle high
// and run well below clk.
module dac_serial_bank
    import dsb_pkg::*;
#(
    parameter int N_CH  = CH_N,
    parameter int C_W   = CODE_W,
    parameter int S_W   = SEL_W,
    localparam int F_W  = S_W + C_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdi,
    input  logic                 sclk,
    input  logic                 ld,
    output logic                 sdo,
    output logic [N_CH*C_W-1:0]  ch_code
);
    // Pin order in the synchroniser: {sdi, sclk, ld}
    localparam logic [2:0] PIN_IDLE = 3'b011;

    logic [2:0]     pin_lvl;
    logic [2:0]     pin_rise;
    logic           sdi_lvl;
    logic           sclk_rise;
    logic           ld_lvl;
    logic           ld_rise;
    logic           shift_en;
    logic [F_W-1:0] frame;

    dsb_sync_edge #(.W(3), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({sdi, sclk, ld}),
        .lvl   (pin_lvl),
        .rise  (pin_rise)
    );

    // Split synchronised pins and gate shifting by the strobe level.
    always_comb begin
        sdi_lvl   = pin_lvl[2];
        sclk_rise = pin_rise[1];
        ld_lvl    = pin_lvl[0];
        ld_rise   = pin_rise[0];
        shift_en  = sclk_rise && !ld_lvl;
    end

    dsb_shift #(.FRAME_W(F_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .bit_in    (sdi_lvl),
        .frame     (frame),
        .chain_out (sdo)
    );

    dsb_latch_bank #(.CH_N(N_CH), .CODE_W(C_W), .SEL_W(S_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (ld_rise),
        .sel    (frame[F_W-1 -: S_W]),
        .code   (frame[C_W-1:0]),
        .codes  (ch_code)
    );
endmodule

// File: rtl/dac_serial_bank_chk.sv
// Module: dac_serial_bank_chk
// Property checker bound to dac_serial_bank. It watches the channel
// outputs, the chain output and the internal strobe and shift events.
module dac_serial_bank_chk #(
    parameter int N_CH = 8,
    parameter int C_W  = 8,
    parameter int F_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CH*C_W-1:0] ch_code,
    input  logic                sdo,
    input  logic                ld_rise,
    input  logic                shift_en,
    input  logic [F_W-1:0]      frame
);
    localparam int S_W = F_W - C_W;

    logic [N_CH*C_W-1:0] prev_code_q;
    logic [N_CH-1:0]     changed;
    logic [S_W-1:0]      sel_now;

    // Copy of last cycle's outputs for the change mask.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_code_q <= '0;
        else        prev_code_q <= ch_code;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_chg
        assign changed[g] = ch_code[g*C_W +: C_W] != prev_code_q[g*C_W +: C_W];
    end

    assign sel_now = frame[F_W-1 -: S_W];

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> ch_code == '0); // R1
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(changed) <= 1); // R5
    AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rise |=> $stable(ch_code)); // R5
    AST_BAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_rise && (sel_now == '0 || sel_now > S_W'(N_CH))) |=> $stable(ch_code)); // R7
    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame)); // R4
    AST_CHAIN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> sdo == $past(frame[F_W-2])); // R8
endmodule

bind dac_serial_bank dac_serial_bank_chk #(.N_CH(N_CH), .C_W(C_W), .F_W(F_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_code  (ch_code),
    .sdo      (sdo),
    .ld_rise  (ld_rise),
    .shift_en (shift_en),
    .frame    (frame)
);

// File: tb/dac_serial_bank_bench.sv
// Bench for dac_serial_bank: directed frames plus a behavioural
// per-cycle model compared on every falling clk edge.
module dac_serial_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sclk = 1'b1;
    logic        ld = 1'b1;
    logic        sdo;
    logic [63:0] ch_code;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // Bench-side expectations
    int exp_ch [8];
    bit shifted [$];

    // Behavioural model state
    int m_ch [8];
    int m_sr;
    bit hs [4];
    bit hl [4];
    bit hd [4];

    always #2 clk = ~clk; // 250 MHz

    dac_serial_bank u_dac_serial_bank (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sclk(sclk), .ld(ld),
        .sdo(sdo), .ch_code(ch_code)
    );

    function automatic void report(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // Model: pins pass through a 4-deep sample history.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (hs[i]) begin hs[i] = 1; hl[i] = 1; hd[i] = 0; end
            m_sr = 0;
            foreach (m_ch[i]) m_ch[i] = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                hs[i] = hs[i-1]; hl[i] = hl[i-1]; hd[i] = hd[i-1];
            end
            hs[0] = sclk; hl[0] = ld; hd[0] = sdi;
            if (hl[2] && !hl[3]) begin
                int a;
                a = (m_sr >> 8) & 15;
                if (a >= 1 && a <= 8) m_ch[a-1] = m_sr & 255;
            end
            if (hs[2] && !hs[3] && !hl[2]) m_sr = ((m_sr << 1) | int'(hd[2])) & 12'hFFF;
        end
    end

    // Per-cycle comparison against the model (R2, R8 stream view)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 8; i++)
                report("R2 model ch", int'(ch_code[i*8 +: 8]), m_ch[i]);
            report("R8 model sdo", int'(sdo), (m_sr >> 11) & 1);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Shift a frame MSB first; optional sdi glitches while sclk is steady.
    task automatic shift_frame(input logic [11:0] f, input bit ld_hi, input bit glitch);
        ld = ld_hi;
        wait_n(2);
        for (int i = 11; i >= 0; i--) begin
            sclk = 1'b0;
            sdi = glitch ? ~f[i] : f[i];
            wait_n(2);
            sdi = f[i];
            wait_n(2);
            sclk = 1'b1;
            wait_n(3);
            if (!ld_hi) begin
                shifted.push_back(f[i]);
                report("R8 sdo twelve shifts back", int'(sdo),
                       shifted.size() >= 12 ? int'(shifted[shifted.size()-12]) : 0);
            end
            if (glitch) sdi = ~f[i];
            wait_n(1);
        end
    endtask

    task automatic commit();
        ld = 1'b0;
        wait_n(2);
        ld = 1'b1;
        wait_n(4);
    endtask

    task automatic write(input int ch, input int code, input bit glitch);
        shift_frame({4'(ch), 8'(code)}, 1'b0, glitch);
        ld = 1'b1;
        wait_n(4);
        if (ch >= 1 && ch <= 8) exp_ch[ch-1] = code;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 8; i++) report(req, int'(ch_code[i*8 +: 8]), exp_ch[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        foreach (exp_ch[i]) exp_ch[i] = 0;
        wait_n(4);
        check_all("R1 reset clears codes");
        rst_n = 1'b1;
        wait_n(2);

        // R2, R6: each select value 1..8 reaches its own channel
        for (int k = 1; k <= 8; k++) begin
            write(k, (k * 37 + 5) & 255, 1'b0);
            check_all("R6 select to channel");
        end

        // R7: unused select values leave all codes alone
        write(0, 8'hFF, 1'b0);
        check_all("R7 select 0 ignored");
        write(9, 8'h00, 1'b0);
        check_all("R7 select 9 ignored");
        write(15, 8'h5A, 1'b0);
        check_all("R7 select 15 ignored");

        // R3: sdi toggles while sclk is steady
        write(3, 8'hA5, 1'b1);
        report("R3 glitch-free sampling", int'(ch_code[16 +: 8]), 8'hA5);

        // R10: overwrite, last write wins
        write(2, 8'h01, 1'b0);
        write(2, 8'hFE, 1'b0);
        check_all("R10 last write wins");

        // R4: clocks with ld high are ignored; bare strobe reloads old frame
        write(4, 8'h3C, 1'b0);
        shift_frame({4'd5, 8'h77}, 1'b1, 1'b0);
        commit();
        check_all("R4 shift gated by strobe");
        report("R4 channel 5 not written", int'(ch_code[32 +: 8]), exp_ch[4]);

        // R9 and R5: commit latency and single-channel write
        shift_frame({4'd7, 8'hC3}, 1'b0, 1'b0);
        ld = 1'b1;
        wait_n(2);
        report("R9 not yet visible", int'(ch_code[48 +: 8]), exp_ch[6]);
        wait_n(1);
        report("R9 visible on third edge", int'(ch_code[48 +: 8]), 8'hC3);
        exp_ch[6] = 8'hC3;
        wait_n(2);
        check_all("R5 only selected channel");

        // R8: chain of two frames; second frame's bits follow the first
        shift_frame({4'd1, 8'h96}, 1'b0, 1'b0);
        shift_frame({4'd8, 8'h69}, 1'b0, 1'b0);
        ld = 1'b1;
        wait_n(4);
        exp_ch[7] = 8'h69;
        check_all("R8 chained frames");

        // R1: reset mid-run clears everything again
        rst_n = 1'b0;
        wait_n(2);
        foreach (exp_ch[i]) exp_ch[i] = 0;
        check_all("R1 reset clears codes");
        report("R1 sdo cleared", int'(sdo), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule